// File: doc/BRIEF.md
# Framed Packet Transmitter Sequencer

This block turns one message into a framed byte stream for a serial link. A caller presents a header (message kind, subsystem number, command code and a 16-bit payload length) on a valid/ready header port. The block then emits, one byte per accepted transfer on a valid/ready output port: a fixed start marker, the length (low byte first), a combined kind/subsystem byte, the command, the payload bytes pulled from a valid/ready payload port, and a closing check byte. The check byte is the XOR of every emitted byte except the start marker.

It also enforces blocking request/response ordering. Once a frame of the synchronous-request kind has been fully sent, no new header is accepted until a pulse on `resp_seen` reports that the matching response arrived. Back-pressure works as follows. The output byte is held with `out_valid` high until `out_ready` is seen. During the payload phase, the payload port is a direct pass-through: `pl_ready` follows `out_ready`, and `out_valid` follows `pl_valid`. The header port is ready only when the block is idle and no request is outstanding.

Top module: `framed_tx_seq`

## Requirements
- R1: After reset, `busy`, `out_valid`, `pl_ready` and `req_pending` are low and `hdr_ready` is high.
- R2: The first byte of every frame is 0xFE. It appears on the output in the cycle after the header is accepted.
- R3: Bytes two and three carry the 16-bit length, low byte first.
- R4: Byte four is the kind in bits 7:5 and the subsystem in bits 4:0. Byte five is the command code.
- R5: After the command byte, exactly `length` payload bytes are taken from the payload port, in order. `pl_ready` is high only during the payload phase.
- R6: The last byte of a frame is the XOR of all frame bytes from the length low byte through the last payload byte.
- R7: A frame with length 0 goes from the command byte straight to the check byte. It takes no payload byte, even if `pl_valid` is high.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` keeps its value in the next cycle.
- R9: A header is accepted only when `busy` is low and `req_pending` is low. `busy` is high from the cycle after acceptance until the check byte is transferred.
- R10: When a frame of kind 1 (synchronous request) finishes, `req_pending` rises and `hdr_ready` stays low. A `resp_seen` pulse clears `req_pending` in the next cycle.
- R11: A `resp_seen` pulse while no request is pending has no effect: a later synchronous request still sets `req_pending`.
- R12: Frames of kind 2 (asynchronous) and kind 3 (synchronous response) leave `req_pending` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Header offered |
| hdr_ready | output | 1 | Header can be accepted |
| hdr_kind | input | 3 | Message kind (1 sync request, 2 async, 3 sync response) |
| hdr_sub | input | 5 | Subsystem number |
| hdr_cmd | input | 8 | Command code |
| hdr_len | input | 16 | Payload length in bytes |
| pl_valid | input | 1 | Payload byte offered |
| pl_ready | output | 1 | Payload byte taken |
| pl_data | input | 8 | Payload byte |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Output byte accepted by link |
| out_data | output | 8 | Output byte |
| resp_seen | input | 1 | Pulse: matching response received |
| busy | output | 1 | Frame in progress |
| req_pending | output | 1 | Synchronous request outstanding |

## Verification
The hardest states to reach are those where back-pressure lands on the payload pass-through. There, a stall on the output must also freeze the payload source. A related case is the zero-length frame with a payload byte already waiting, which must not be consumed. The stimulus reaches these states in three ways. A pseudo-random `out_ready` pattern runs across long frames. The payload driver inserts gaps of its own. A zero-length frame is sent while `pl_valid` is held high with a junk byte. Lock behaviour is reached by completing a request frame and then offering headers against the lock before the response pulse.

// File: rtl/ftx_pkg.sv
package ftx_pkg;
  localparam int BYTE_W = 8;
  localparam int LEN_W  = 2 * BYTE_W;
  localparam int KIND_W = 3;
  localparam int SUB_W  = BYTE_W - KIND_W;

  localparam logic [BYTE_W-1:0] START_MARK    = 8'hFE;
  localparam logic [KIND_W-1:0] KIND_SYNC_REQ = 3'd1;

  typedef enum logic [2:0] {
    PH_IDLE, PH_START, PH_LEN_LO, PH_LEN_HI, PH_KIND, PH_CMD, PH_BODY, PH_CHECK
  } phase_e;

  typedef struct packed {
    logic [KIND_W-1:0] kind;
    logic [SUB_W-1:0]  sub;
    logic [BYTE_W-1:0] cmd;
    logic [LEN_W-1:0]  len;
  } hdr_t;
endpackage

// File: rtl/ftx_xor_acc.sv
module ftx_xor_acc #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] acc
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) acc <= '0;
    else if (en)       acc <= acc ^ din;
  end
endmodule

// File: rtl/ftx_req_lock.sv
module ftx_req_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic pending
);
  // set wins: a request completing overrides a stray response pulse
  always_ff @(posedge clk) begin
    if (!rst_n)      pending <= 1'b0;
    else if (set_i)  pending <= 1'b1;
    else if (clr_i)  pending <= 1'b0;
  end
endmodule

// File: rtl/ftx_seq_ctrl.sv
module ftx_seq_ctrl
  import ftx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_fire,
  input  hdr_t              hdr_in,
  input  logic              pl_valid,
  input  logic [BYTE_W-1:0] pl_data,
  input  logic              out_ready,
  input  logic [BYTE_W-1:0] check_val,
  output phase_e            phase,
  output logic              out_valid,
  output logic [BYTE_W-1:0] out_data,
  output logic              pl_ready,
  output logic              sum_en,
  output logic              frame_done,
  output logic [KIND_W-1:0] kind_q
);
  hdr_t             hdr_q;
  logic [LEN_W-1:0] left_q;
  phase_e           nxt;
  logic             fire;

  assign kind_q = hdr_q.kind;

  always_comb begin
    out_valid = (phase != PH_IDLE);
    out_data  = '0;
    pl_ready  = 1'b0;
    unique case (phase)
      PH_START:  out_data = START_MARK;
      PH_LEN_LO: out_data = hdr_q.len[BYTE_W-1:0];
      PH_LEN_HI: out_data = hdr_q.len[LEN_W-1:BYTE_W];
      PH_KIND:   out_data = {hdr_q.kind, hdr_q.sub};
      PH_CMD:    out_data = hdr_q.cmd;
      PH_BODY: begin
        out_valid = pl_valid;
        out_data  = pl_data;
        pl_ready  = out_ready;
      end
      PH_CHECK:  out_data = check_val;
      default:   out_data = '0;
    endcase
  end

  assign fire       = out_valid && out_ready;
  assign sum_en     = fire && (phase != PH_START) && (phase != PH_CHECK);
  assign frame_done = fire && (phase == PH_CHECK);

  always_comb begin
    nxt = phase;
    unique case (phase)
      PH_IDLE:   if (hdr_fire) nxt = PH_START;
      PH_START:  if (fire) nxt = PH_LEN_LO;
      PH_LEN_LO: if (fire) nxt = PH_LEN_HI;
      PH_LEN_HI: if (fire) nxt = PH_KIND;
      PH_KIND:   if (fire) nxt = PH_CMD;
      PH_CMD:    if (fire) nxt = (hdr_q.len == '0) ? PH_CHECK : PH_BODY;
      PH_BODY:   if (fire && left_q == LEN_W'(1)) nxt = PH_CHECK;
      PH_CHECK:  if (fire) nxt = PH_IDLE;
      default:   nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      hdr_q  <= '0;
      left_q <= '0;
    end else begin
      phase <= nxt;
      if (hdr_fire) begin
        hdr_q  <= hdr_in;
        left_q <= hdr_in.len;
      end else if (fire && phase == PH_BODY) begin
        left_q <= left_q - LEN_W'(1);
      end
    end
  end
endmodule

// File: rtl/framed_tx_seq.sv
module framed_tx_seq
  import ftx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_valid,
  output logic              hdr_ready,
  input  logic [KIND_W-1:0] hdr_kind,
  input  logic [SUB_W-1:0]  hdr_sub,
  input  logic [BYTE_W-1:0] hdr_cmd,
  input  logic [LEN_W-1:0]  hdr_len,
  input  logic              pl_valid,
  output logic              pl_ready,
  input  logic [BYTE_W-1:0] pl_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  input  logic              resp_seen,
  output logic              busy,
  output logic              req_pending
);
  phase_e            phase;
  hdr_t              hdr_in;
  logic              hdr_fire, sum_en, frame_done;
  logic [BYTE_W-1:0] check_val;
  logic [KIND_W-1:0] kind_q;

  assign hdr_in    = '{kind: hdr_kind, sub: hdr_sub, cmd: hdr_cmd, len: hdr_len};
  assign hdr_ready = (phase == PH_IDLE) && !req_pending;
  assign hdr_fire  = hdr_valid && hdr_ready;
  assign busy      = (phase != PH_IDLE);

  ftx_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .hdr_fire   (hdr_fire),
    .hdr_in     (hdr_in),
    .pl_valid   (pl_valid),
    .pl_data    (pl_data),
    .out_ready  (out_ready),
    .check_val  (check_val),
    .phase      (phase),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .pl_ready   (pl_ready),
    .sum_en     (sum_en),
    .frame_done (frame_done),
    .kind_q     (kind_q)
  );

  ftx_xor_acc #(.W(BYTE_W)) u_sum (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (hdr_fire),
    .en    (sum_en),
    .din   (out_data),
    .acc   (check_val)
  );

  ftx_req_lock u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (frame_done && (kind_q == KIND_SYNC_REQ)),
    .clr_i   (resp_seen),
    .pending (req_pending)
  );
endmodule

// File: rtl/ftx_chk.sv
module ftx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hdr_valid,
  input logic       hdr_ready,
  input logic       pl_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       resp_seen,
  input logic       busy,
  input logic       req_pending
);
  assert_start_mark_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_ready) |=> (out_valid && out_data == 8'hFE));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_ready) |=> busy);

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !out_valid);

  assert_body_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pl_ready |-> busy);

  assert_lock_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_pending |-> !hdr_ready);

  assert_lock_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_pending && resp_seen) |=> !req_pending);
endmodule

bind framed_tx_seq ftx_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hdr_valid   (hdr_valid),
  .hdr_ready   (hdr_ready),
  .pl_ready    (pl_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_data    (out_data),
  .resp_seen   (resp_seen),
  .busy        (busy),
  .req_pending (req_pending)
);

// File: tb/sim_framed_tx_seq.sv
`timescale 1ns/1ps
module sim_framed_tx_seq;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, hdr_valid, hdr_ready, pl_valid, pl_ready, out_valid, out_ready;
  logic resp_seen, busy, req_pending;
  logic [2:0] hdr_kind;
  logic [4:0] hdr_sub;
  logic [7:0] hdr_cmd, pl_data, out_data;
  logic [15:0] hdr_len;

  framed_tx_seq u0 (.*);

  int n_cmp = 0, n_bad = 0, pl_hs = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  bit stall_mode = 0;
  logic [7:0] lfsr = 8'h9D;
  bit hold_pend = 0;
  logic [7:0] hold_data;

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #1;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready = stall_mode ? (lfsr[0] | lfsr[2]) : 1'b1;
  end

  // monitor: scoreboard compare of each transferred byte
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend)
        check(out_valid && out_data == hold_data, "R8 hold", {out_valid, out_data}, {1'b1, hold_data});
      hold_pend = out_valid && !out_ready;
      hold_data = out_data;
      if (pl_valid && pl_ready) pl_hs++;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0) check(0, "R9 unexpected byte", out_data, 0);
        else begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(out_data == e, t, out_data, e);
        end
      end
    end
  end

  task automatic send_frame(input logic [2:0] kind, input logic [4:0] sub,
                            input logic [7:0] cmd, input int len, input bit junk);
    logic [7:0] pay[$];
    logic [7:0] sum;
    sum = 8'(len) ^ 8'(len >> 8) ^ {kind, sub} ^ cmd;
    exp_q.push_back(8'hFE);           tag_q.push_back("R2 start");
    exp_q.push_back(8'(len));         tag_q.push_back("R3 len lo");
    exp_q.push_back(8'(len >> 8));    tag_q.push_back("R3 len hi");
    exp_q.push_back({kind, sub});     tag_q.push_back("R4 kind");
    exp_q.push_back(cmd);             tag_q.push_back("R4 cmd");
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = 8'(i * 13) ^ cmd ^ 8'h5A;
      pay.push_back(b);
      sum ^= b;
      exp_q.push_back(b);             tag_q.push_back("R5 payload");
    end
    exp_q.push_back(sum);             tag_q.push_back(len == 0 ? "R7 check" : "R6 check");
    pl_hs = 0;
    @(posedge clk); #1;
    hdr_valid = 1; hdr_kind = kind; hdr_sub = sub; hdr_cmd = cmd; hdr_len = 16'(len);
    forever begin @(negedge clk); if (hdr_ready) break; end
    @(posedge clk); #1;
    hdr_valid = 0;
    if (junk) begin
      pl_valid = 1; pl_data = 8'hA5;
    end else begin
      for (int i = 0; i < len; i++) begin
        if (i % 5 == 3) begin
          pl_valid = 0;
          @(posedge clk); #1;
        end
        pl_valid = 1; pl_data = pay[i];
        forever begin @(negedge clk); if (pl_ready) break; end
        @(posedge clk); #1;
      end
      pl_valid = 0;
    end
    forever begin @(negedge clk); if (!busy && exp_q.size() == 0) break; end
    pl_valid = 0;
    check(pl_hs == len, len == 0 ? "R7 no payload taken" : "R5 payload count", pl_hs, len);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 0; hdr_valid = 0; pl_valid = 0; resp_seen = 0; out_ready = 1;
    hdr_kind = 0; hdr_sub = 0; hdr_cmd = 0; hdr_len = 0; pl_data = 0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    check(!busy && !out_valid && !pl_ready && !req_pending && hdr_ready, "R1 reset",
          {busy, out_valid, pl_ready, req_pending, hdr_ready}, 5'b00001);
    @(posedge clk); #1; rst_n = 1;

    send_frame(3'd2, 5'd7, 8'h31, 3, 0);
    check(!req_pending, "R12 async", req_pending, 0);
    stall_mode = 1;
    send_frame(3'd2, 5'd1, 8'h44, 0, 1);
    send_frame(3'd3, 5'd30, 8'hC3, 20, 0);
    check(!req_pending, "R12 response", req_pending, 0);
    send_frame(3'd2, 5'd12, 8'h0F, 300, 0);

    @(posedge clk); #1; resp_seen = 1;
    @(posedge clk); #1; resp_seen = 0;
    @(negedge clk);
    check(!req_pending && hdr_ready, "R11 idle pulse", {req_pending, hdr_ready}, 2'b01);

    send_frame(3'd1, 5'd4, 8'h77, 4, 0);
    repeat (2) @(negedge clk);
    check(req_pending && !hdr_ready, "R10 lock set", {req_pending, hdr_ready}, 2'b10);
    @(posedge clk); #1;
    hdr_valid = 1; hdr_kind = 3'd2; hdr_len = 16'd1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(!hdr_ready && !busy && !out_valid, "R9 header held off",
            {hdr_ready, busy, out_valid}, 3'b000);
    end
    @(posedge clk); #1; hdr_valid = 0; resp_seen = 1;
    @(posedge clk); #1; resp_seen = 0;
    @(negedge clk);
    check(!req_pending && hdr_ready, "R10 lock cleared", {req_pending, hdr_ready}, 2'b01);

    send_frame(3'd1, 5'd0, 8'hE1, 0, 1);
    @(negedge clk);
    check(req_pending, "R10 zero-length request", req_pending, 1);
    @(posedge clk); #1; resp_seen = 1;
    @(posedge clk); #1; resp_seen = 0;
    stall_mode = 0;
    send_frame(3'd2, 5'd31, 8'hFF, 1, 0);
    check(!req_pending, "R12 after clear", req_pending, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule